// File: doc/BRIEF.md
# Packet-Command PIO Burst Sequencer

This block is the device side of a packet-command disk interface for programmed I/O. The host loads a byte-count limit into two 8-bit count registers, issues the packet command, and then pushes a twelve-byte command packet through the 16-bit data port. The block reads the starting block address and the block count out of the packet and works out the total length, at 2048 bytes per block. It then returns that data in bursts that never exceed the limit. Each burst is announced by an interrupt, and the size of the burst is written back into the count registers before the burst starts.

The data comes from a built-in block source. Word k of a transfer that starts at block L reads as the low 16 bits of L*1024 + k. When the last burst has been read, a completion interrupt follows. A packet that cannot be handled, a command other than the packet command, or a request for DMA is aborted with an error status. Only programmed I/O is modelled.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset the status register reads 0x40 (ready only), the interrupt output is low and both count registers read 0.
- R2: Register addresses: data port 0, feature (write) and error (read) 1, count low byte 4, count high byte 5, command (write) and status (read) 7. Writing 0xA0 to address 7 while idle with feature bit 0 clear makes status read 0x48 (data request and ready) until six words have been written to the data port.
- R3: Packet byte 2k is the low byte of data word k. Byte 0 is the opcode, which must be 0x28. Bytes 2 to 5 hold the block address, most significant byte first. Bytes 7 and 8 hold the block count, most significant byte first. The transfer length is the count times 2048 bytes, and word k returns the low 16 bits of address*1024 + k.
- R4: Each burst is the smaller of the remaining length and the limit with bit 0 cleared. A limit of 0 or 1 acts as 65534, so an odd limit gives bursts one byte shorter than the limit.
- R5: Before each burst the burst length in bytes is written into the count registers (low byte at 4, high byte at 5).
- R6: Each burst starts with a raised interrupt and status 0x48. After the last word of every burst there is exactly one cycle with status 0xC0 (busy and ready).
- R7: A read of the status register clears the interrupt. If an interrupt is raised in the same cycle, the interrupt stays set.
- R8: After the final burst, or right after the packet when the block count is 0, a completion interrupt is raised and status reads 0x40.
- R9: A read of the data port outside a burst returns 0.
- R10: Feature bit 0 set, a command other than 0xA0, or a packet opcode other than 0x28 each end the command at once. The block raises an interrupt, status reads 0x41 and the error register reads 0x04. The next accepted packet command clears the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 3 | Register address for the current access |
| regWrEn | input | 1 | Write strobe for one cycle |
| regWrData | input | 16 | Write data; 8-bit registers use bits 7:0 |
| regRdEn | input | 1 | Read strobe; marks the read for its side effects |
| regRdData | output | 16 | Read data for regAddr, combinational |
| intrq | output | 1 | Interrupt request to the host |

## Verification
Two functions can fall in the same cycle: the host's status read, which clears the interrupt, and the sequencer raising a new interrupt. This happens in the single busy cycle that follows the last word of a burst, whether the next event is another burst or completion. The bench reads status at exactly that cycle. It expects 0xC0 from the read and expects the interrupt to be asserted afterwards, because the raise has priority. Sweeps cover even, odd, tiny and zero limits together with several block counts and addresses.

// File: rtl/atapi_seq_pkg.sv
package atapi_seq_pkg;
  typedef enum logic [1:0] {S_IDLE, S_PKT, S_BUSY, S_BURST} seqState_t;

  typedef struct packed {
    logic pktClear;
    logic pktWord;
    logic startBurst;
    logic popWord;
  } dpStrobe_t;

  localparam logic [7:0] ST_BSY   = 8'h80;
  localparam logic [7:0] ST_DRDY  = 8'h40;
  localparam logic [7:0] ST_DRQ   = 8'h08;
  localparam logic [7:0] ST_ERR   = 8'h01;
  localparam logic [7:0] ERR_ABRT = 8'h04;

  localparam logic [7:0] CMD_PACKET = 8'hA0;
  localparam logic [7:0] OP_READ10  = 8'h28;

  localparam logic [2:0] A_DATA  = 3'd0;
  localparam logic [2:0] A_FEAT  = 3'd1;
  localparam logic [2:0] A_CNTLO = 3'd4;
  localparam logic [2:0] A_CNTHI = 3'd5;
  localparam logic [2:0] A_CMD   = 3'd7;
endpackage

// File: rtl/atapi_seq_ctrl.sv
module atapi_seq_ctrl
  import atapi_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWr,
  input  logic [7:0] cmdCode,
  input  logic       dmaSel,
  input  logic       dataWr,
  input  logic       dataRd,
  input  logic       statusRd,
  input  logic       pktLast,
  input  logic       opOk,
  input  logic       remZero,
  input  logic       burstLastWord,
  output dpStrobe_t  strobe,
  output logic [7:0] status,
  output logic       errFlag,
  output logic       intrq
);
  seqState_t state, nextState;
  logic errQ, nextErr, setIntr, intrQ;

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextErr   = errQ;
    setIntr   = 1'b0;
    unique case (state)
      S_IDLE: if (cmdWr) begin
        if (cmdCode == CMD_PACKET && !dmaSel) begin
          nextState       = S_PKT;
          nextErr         = 1'b0;
          strobe.pktClear = 1'b1;
        end else begin
          nextErr = 1'b1;
          setIntr = 1'b1;
        end
      end
      S_PKT: if (dataWr) begin
        strobe.pktWord = 1'b1;
        if (pktLast) begin
          if (opOk) nextState = S_BUSY;
          else begin
            nextState = S_IDLE;
            nextErr   = 1'b1;
            setIntr   = 1'b1;
          end
        end
      end
      S_BUSY: begin
        setIntr = 1'b1;
        if (remZero) nextState = S_IDLE;
        else begin
          nextState         = S_BURST;
          strobe.startBurst = 1'b1;
        end
      end
      S_BURST: if (dataRd) begin
        strobe.popWord = 1'b1;
        if (burstLastWord) nextState = S_BUSY;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      errQ  <= 1'b0;
      intrQ <= 1'b0;
    end else begin
      state <= nextState;
      errQ  <= nextErr;
      if (setIntr) intrQ <= 1'b1;
      else if (statusRd) intrQ <= 1'b0;
    end
  end

  always_comb begin
    unique case (state)
      S_PKT, S_BURST: status = ST_DRQ | ST_DRDY;
      S_BUSY:         status = ST_BSY | ST_DRDY;
      default:        status = errQ ? (ST_DRDY | ST_ERR) : ST_DRDY;
    endcase
  end

  assign errFlag = errQ;
  assign intrq   = intrQ;

  a_r2_pkt_entry: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && cmdWr && cmdCode == CMD_PACKET && !dmaSel) |=> (status == 8'h48));

  a_r6_burst_intr: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BUSY && !remZero) |=> (intrq && state == S_BURST));

  a_r7_intr_clear: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && state == S_BURST) |=> !intrq);

  a_r10_abort_status: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && cmdWr && cmdCode != CMD_PACKET) |=> (status == 8'h41 && intrq));
endmodule

// File: rtl/atapi_seq_dp.sv
module atapi_seq_dp
  import atapi_seq_pkg::*;
#(
  parameter int BLK_LOG2  = 11,
  parameter int PKT_WORDS = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strobe,
  input  logic [2:0]  regAddr,
  input  logic        regWrEn,
  input  logic [15:0] regWrData,
  input  logic [7:0]  status,
  input  logic        errFlag,
  output logic [15:0] regRdData,
  output logic        dmaSel,
  output logic        pktLast,
  output logic        opOk,
  output logic        remZero,
  output logic        burstLastWord
);
  localparam int CNT_W    = 16;
  localparam int REM_W    = CNT_W + BLK_LOG2;
  localparam int WPB_LOG2 = BLK_LOG2 - 1;
  localparam int LBA_KEEP = 16 - WPB_LOG2;
  localparam int IDX_W    = $clog2(PKT_WORDS);

  logic             featQ;
  logic [15:0]      cntQ;
  logic [IDX_W-1:0] pktIdx;
  logic [7:0]       opcodeQ;
  logic [LBA_KEEP-1:0] lbaKeep;
  logic [CNT_W-1:0] blkCnt;
  logic [REM_W-1:0] remBytes;
  logic [14:0]      burstWords;
  logic [15:0]      wordPtr;
  logic [15:0]      limEff, burstLen;

  always_comb begin
    limEff   = {cntQ[15:1], 1'b0};
    if (limEff == 16'd0) limEff = 16'hFFFE;
    burstLen = (remBytes <= REM_W'(limEff)) ? remBytes[15:0] : limEff;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      featQ      <= 1'b0;
      cntQ       <= '0;
      pktIdx     <= '0;
      opcodeQ    <= '0;
      lbaKeep    <= '0;
      blkCnt     <= '0;
      remBytes   <= '0;
      burstWords <= '0;
      wordPtr    <= '0;
    end else begin
      if (regWrEn && regAddr == A_FEAT) featQ <= regWrData[0];
      if (strobe.startBurst) begin
        cntQ       <= burstLen;
        burstWords <= burstLen[15:1];
      end else if (regWrEn && regAddr == A_CNTLO) cntQ[7:0]  <= regWrData[7:0];
      else if (regWrEn && regAddr == A_CNTHI)     cntQ[15:8] <= regWrData[7:0];

      if (strobe.pktClear) pktIdx <= '0;
      else if (strobe.pktWord) begin
        pktIdx <= pktIdx + 1'b1;
        case (pktIdx)
          IDX_W'(0): opcodeQ      <= regWrData[7:0];
          IDX_W'(2): lbaKeep      <= regWrData[8 +: LBA_KEEP];
          IDX_W'(3): blkCnt[15:8] <= regWrData[15:8];
          IDX_W'(4): blkCnt[7:0]  <= regWrData[7:0];
          IDX_W'(PKT_WORDS-1): begin
            remBytes <= {blkCnt, {BLK_LOG2{1'b0}}};
            wordPtr  <= {lbaKeep, {WPB_LOG2{1'b0}}};
          end
          default: ;
        endcase
      end

      if (strobe.popWord) begin
        wordPtr    <= wordPtr + 16'd1;
        remBytes   <= remBytes - REM_W'(2);
        burstWords <= burstWords - 15'd1;
      end
    end
  end

  assign dmaSel        = featQ;
  assign pktLast       = (pktIdx == IDX_W'(PKT_WORDS-1));
  assign opOk          = (opcodeQ == OP_READ10);
  assign remZero       = (remBytes == '0);
  assign burstLastWord = (burstWords == 15'd1);

  always_comb begin
    unique case (regAddr)
      A_DATA:  regRdData = (burstWords != '0) ? wordPtr : 16'h0000;
      A_FEAT:  regRdData = {8'h00, errFlag ? ERR_ABRT : 8'h00};
      A_CNTLO: regRdData = {8'h00, cntQ[7:0]};
      A_CNTHI: regRdData = {8'h00, cntQ[15:8]};
      A_CMD:   regRdData = {8'h00, status};
      default: regRdData = 16'h0000;
    endcase
  end

  a_r4_even_burst: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startBurst |=> !cntQ[0]);

  a_r4_within_limit: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.startBurst && cntQ >= 16'd2) |=> (cntQ <= $past(cntQ)));

  a_r3_block_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pktWord && pktLast) |=> (remBytes[BLK_LOG2-1:0] == '0));

  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popWord |-> (remBytes >= REM_W'(2) && burstWords != '0));
endmodule

// File: rtl/atapi_pio_seq.sv
module atapi_pio_seq
  import atapi_seq_pkg::*;
#(
  parameter int BLK_LOG2  = 11,
  parameter int PKT_WORDS = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic        regWrEn,
  input  logic [15:0] regWrData,
  input  logic        regRdEn,
  output logic [15:0] regRdData,
  output logic        intrq
);
  dpStrobe_t  strobe;
  logic [7:0] status;
  logic       errFlag, dmaSel, pktLast, opOk, remZero, burstLastWord;

  atapi_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdWr(regWrEn && regAddr == A_CMD),
    .cmdCode(regWrData[7:0]),
    .dmaSel(dmaSel),
    .dataWr(regWrEn && regAddr == A_DATA),
    .dataRd(regRdEn && regAddr == A_DATA),
    .statusRd(regRdEn && regAddr == A_CMD),
    .pktLast(pktLast), .opOk(opOk), .remZero(remZero),
    .burstLastWord(burstLastWord),
    .strobe(strobe), .status(status), .errFlag(errFlag), .intrq(intrq)
  );

  atapi_seq_dp #(.BLK_LOG2(BLK_LOG2), .PKT_WORDS(PKT_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .status(status), .errFlag(errFlag), .regRdData(regRdData),
    .dmaSel(dmaSel), .pktLast(pktLast), .opOk(opOk),
    .remZero(remZero), .burstLastWord(burstLastWord)
  );
endmodule

// File: tb/atapi_pio_seq_test.sv
`timescale 1ns/1ps
module atapi_pio_seq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [15:0] regRdData;
  logic        intrq;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  atapi_pio_seq uut (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 190000", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(posedge clk); #1;
    regRdEn = 1'b0;
  endtask

  task automatic waitIntr(input string req);
    int n = 0;
    while (!intrq && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(req, int'(intrq), 1);
  endtask

  task automatic sendPacket(input logic [7:0] op, input logic [31:0] lba, input logic [15:0] blocks);
    wr(3'd0, {8'h00, op});
    wr(3'd0, {lba[23:16], lba[31:24]});
    wr(3'd0, {lba[7:0], lba[15:8]});
    wr(3'd0, {blocks[15:8], 8'h00});
    wr(3'd0, {8'h00, blocks[7:0]});
    wr(3'd0, 16'h0000);
  endtask

  // Full transfer; probe=1 reads status in the busy cycle after each burst (R7 overlap)
  task automatic runXfer(input int limit, input int blocks, input logic [31:0] lba, input bit probe);
    logic [15:0] v;
    logic [15:0] ptr;
    int rem, lim, exp, bad;
    wr(3'd4, 16'(limit & 255));
    wr(3'd5, 16'((limit >> 8) & 255));
    wr(3'd1, 16'h0000);
    wr(3'd7, 16'h00A0);
    rd(3'd7, v); chk("R2 packet phase status", int'(v), 'h48);
    sendPacket(8'h28, lba, 16'(blocks));
    rem = blocks * 2048;
    lim = limit & 'hFFFE;
    if (lim == 0) lim = 65534;
    ptr = {lba[5:0], 10'b0};
    while (rem > 0) begin
      waitIntr("R6 burst interrupt");
      rd(3'd7, v); chk("R6 burst status", int'(v), 'h48);
      chk("R7 status read clears interrupt", int'(intrq), 0);
      exp = (rem <= lim) ? rem : lim;
      rd(3'd4, v); chk("R5 count low / R4 burst size", int'(v), exp & 255);
      rd(3'd5, v); chk("R5 count high / R4 burst size", int'(v), (exp >> 8) & 255);
      bad = 0;
      for (int k = 0; k < exp / 2; k++) begin
        rd(3'd0, v);
        if (v != ptr && bad == 0) begin
          bad = 1;
          chk("R3 data word", int'(v), int'(ptr));
        end
        ptr = ptr + 16'd1;
      end
      if (bad == 0) chk("R3 burst data", 0, 0);
      rem -= exp;
      if (probe) begin
        rd(3'd7, v); chk("R6 busy cycle status", int'(v), 'hC0);
        chk("R7 raise wins over status read", int'(intrq), 1);
      end
    end
    waitIntr("R8 completion interrupt");
    rd(3'd7, v); chk("R8 completion status", int'(v), 'h40);
    rd(3'd0, v); chk("R9 idle data read", int'(v), 0);
  endtask

  task automatic checkAbort(input string req);
    logic [15:0] v;
    waitIntr(req);
    rd(3'd7, v); chk(req, int'(v), 'h41);
    rd(3'd1, v); chk(req, int'(v), 'h04);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(3'd7, v); chk("R1 reset status", int'(v), 'h40);
    chk("R1 reset interrupt", int'(intrq), 0);
    rd(3'd4, v); chk("R1 reset count low", int'(v), 0);
    rd(3'd5, v); chk("R1 reset count high", int'(v), 0);
    rd(3'd0, v); chk("R9 data read while idle", int'(v), 0);

    runXfer(5120, 1, 32'd0, 1'b0);
    runXfer(5120, 3, 32'd7, 1'b1);
    runXfer(5, 2, 32'd1, 1'b0);      // R4 odd limit
    runXfer(2, 1, 32'd2, 1'b1);
    runXfer(0, 2, 32'd3, 1'b0);      // R4 zero limit
    runXfer(1, 1, 32'h01020304, 1'b0);
    runXfer(4095, 2, 32'd63, 1'b1);
    runXfer(2048, 2, 32'd5, 1'b0);
    runXfer(6, 0, 32'd0, 1'b1);      // R8 zero blocks

    // R10 DMA selected
    wr(3'd1, 16'h0001);
    wr(3'd7, 16'h00A0);
    checkAbort("R10 feature bit abort");
    wr(3'd1, 16'h0000);
    // R10 unknown command
    wr(3'd7, 16'h00EC);
    checkAbort("R10 unknown command abort");
    // R10 bad opcode, then recovery clears ERR
    wr(3'd7, 16'h00A0);
    rd(3'd7, v); chk("R10 error cleared by new packet", int'(v), 'h48);
    sendPacket(8'h12, 32'd0, 16'd1);
    checkAbort("R10 bad opcode abort");
    runXfer(1024, 1, 32'd9, 1'b0);

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule